// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Controller

This block sits between an 8-bit console's CPU and video buses and the cartridge ROMs, turning the small address windows that the processor and the picture unit see into wide, banked ROM addresses. Software configures it through an unusual one-bit port. Each write anywhere in the upper half of the CPU map (address bit 15 set) carries one configuration bit in data bit 0. After five such writes, the collected 5-bit value lands in one of four internal registers. The address bits 14:13 of the fifth write pick the register. A write with data bit 7 set abandons any partial load and forces the control register into its safe PRG layout.

The control register picks how the program window is split: two 16 KB halves with the upper half fixed to the last bank, two halves with the lower half fixed to bank 0, or one 32 KB bank. It also picks whether the pattern space is one 8 KB bank or two 4 KB banks, and it supplies the nametable mirroring code. Bank numbers are masked by the bank counts set as parameters, so a selection past the end of the ROM wraps around.

Top module: `serial_bank_ctrl`

## Requirements
- R1: A write has effect only when `wrEn` is high and `wrAddrHi[2]` (CPU address bit 15) is 1. Any other write leaves the registers and the shift progress untouched, including writes with `serClear` high.
- R2: An accepted write with `serClear` (data bit 7) at 1 clears the shift progress and sets control bits 3 and 2, and control bits 4, 1 and 0 keep their values.
- R3: An accepted write with `serClear` at 0 shifts `serBit` in, least significant bit first. The fifth such write commits the 5-bit value, and the first four change no register. The shift progress then starts again from empty.
- R4: On the committing write, `wrAddrHi[1:0]` selects the target register: 0 control, 1 first pattern bank, 2 second pattern bank, 3 program bank. Only bits 3:0 of the program register are kept.
- R5: `mirror` equals control bits 1:0. The codes are 0 single-screen lower, 1 single-screen upper, 2 vertical and 3 horizontal.
- R6: With control bits 3:2 = 11, `cpuAddr[14]`=0 uses the program register as the bank and `cpuAddr[14]`=1 uses bank PRG_BANKS16-1. In every mode, `prgAddr` = {bank (4 bits), `cpuAddr[13:0]`}.
- R7: With control bits 3:2 = 10, `cpuAddr[14]`=0 uses bank 0 and `cpuAddr[14]`=1 uses the program register.
- R8: With control bit 3 = 0, the 16 KB bank number is {program register bits 3:1, `cpuAddr[14]`}.
- R9: With control bit 4 = 1, `ppuAddr[12]`=0 uses the first pattern register as the 4 KB bank and `ppuAddr[12]`=1 uses the second. In every mode, `chrAddr` = {bank (5 bits), `ppuAddr[11:0]`}.
- R10: With control bit 4 = 0, the 4 KB bank number is {first pattern register bits 4:1, `ppuAddr[12]`}.
- R11: When `rstN` is low, the control register is set to 12 (binary 01100), the other three registers to 0 and the shift progress to empty.
- R12: The program bank number is ANDed with PRG_BANKS16-1 and the pattern bank number with CHR_BANKS4-1. Both counts are powers of two. The defaults are 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrAddrHi | input | 3 | CPU write address bits 15:13 |
| serBit | input | 1 | CPU write data bit 0 |
| serClear | input | 1 | CPU write data bit 7 |
| cpuAddr | input | 15 | CPU read address bits 14:0 inside the program window |
| ppuAddr | input | 13 | Video fetch address bits 12:0 inside the pattern space |
| prgAddr | output | 18 | Banked program ROM address |
| chrAddr | output | 17 | Banked pattern ROM address |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The checker runs a shift counter of its own. On every cycle it checks that a commit strobe comes only on the fifth clean accepted write and that a clearing write always raises the abort strobe. It also checks that ignored or clearing writes leave the mirroring code unchanged, that the offset bits pass straight through and that bank numbers never exceed their masks. Only the bench scenarios can show which register a load reaches and which bank each PRG and CHR layout produces. The same holds for the control bits forced by an abort partway through a load and for the reset values.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int SHIFT_LEN = 5;
  localparam int REG_W     = SHIFT_LEN;
  localparam int PRG_SEL_W = 4;
  localparam int PRG_OFS_W = 14;
  localparam int CHR_OFS_W = 12;
  localparam int PRG_AW    = PRG_SEL_W + PRG_OFS_W;
  localparam int CHR_AW    = REG_W + CHR_OFS_W;

  typedef enum logic [1:0] {
    TGT_CTRL = 2'd0,
    TGT_CHR0 = 2'd1,
    TGT_CHR1 = 2'd2,
    TGT_PRG  = 2'd3
  } sbc_target_e;

  typedef struct packed {
    logic              abort;
    logic              commit;
    sbc_target_e       target;
    logic [REG_W-1:0]  value;
  } sbc_strobe_t;

  localparam logic [REG_W-1:0] CTRL_RESET = 5'b01100;
endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddrHi,
  input  logic        serBit,
  input  logic        serClear,
  output sbc_strobe_t strb
);
  localparam int CNT_W = $clog2(SHIFT_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SHIFT_LEN - 1);

  logic [CNT_W-1:0]     shiftCnt;
  logic [SHIFT_LEN-2:0] shiftAcc;
  logic                 accepted;

  assign accepted = wrEn && wrAddrHi[2];

  always_comb begin
    strb = '0;
    if (accepted) begin
      if (serClear) begin
        strb.abort = 1'b1;
      end else if (shiftCnt == LAST_IDX) begin
        strb.commit = 1'b1;
        strb.target = sbc_target_e'(wrAddrHi[1:0]);
        strb.value  = {serBit, shiftAcc};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftCnt <= '0;
      shiftAcc <= '0;
    end else if (accepted) begin
      if (serClear || shiftCnt == LAST_IDX) begin
        shiftCnt <= '0;
        shiftAcc <= '0;
      end else begin
        shiftAcc[shiftCnt[$clog2(SHIFT_LEN-1)-1:0]] <= serBit;
        shiftCnt <= shiftCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbc_dp.sv
module sbc_dp
  import sbc_pkg::*;
#(
  parameter int PRG_BANKS16 = 8,
  parameter int CHR_BANKS4  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbc_strobe_t       strb,
  input  logic [14:0]       cpuAddr,
  input  logic [12:0]       ppuAddr,
  output logic [PRG_AW-1:0] prgAddr,
  output logic [CHR_AW-1:0] chrAddr,
  output logic [1:0]        mirror
);
  localparam logic [PRG_SEL_W-1:0] PRG_MASK = PRG_SEL_W'(PRG_BANKS16 - 1);
  localparam logic [REG_W-1:0]     CHR_MASK = REG_W'(CHR_BANKS4 - 1);
  localparam logic [PRG_SEL_W-1:0] PRG_LAST = PRG_SEL_W'(PRG_BANKS16 - 1);

  logic [REG_W-1:0]     ctrlReg, chr0Reg, chr1Reg;
  logic [PRG_SEL_W-1:0] prgReg;
  logic [PRG_SEL_W-1:0] prgBank;
  logic [REG_W-1:0]     chrBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RESET;
      chr0Reg <= '0;
      chr1Reg <= '0;
      prgReg  <= '0;
    end else if (strb.abort) begin
      ctrlReg[3:2] <= 2'b11;
    end else if (strb.commit) begin
      unique case (strb.target)
        TGT_CTRL: ctrlReg <= strb.value;
        TGT_CHR0: chr0Reg <= strb.value;
        TGT_CHR1: chr1Reg <= strb.value;
        TGT_PRG:  prgReg  <= strb.value[PRG_SEL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    if (ctrlReg[3]) begin
      if (ctrlReg[2]) prgBank = cpuAddr[14] ? PRG_LAST : prgReg;
      else            prgBank = cpuAddr[14] ? prgReg : '0;
    end else begin
      prgBank = {prgReg[PRG_SEL_W-1:1], cpuAddr[14]};
    end
  end

  always_comb begin
    if (ctrlReg[4]) chrBank = ppuAddr[12] ? chr1Reg : chr0Reg;
    else            chrBank = {chr0Reg[REG_W-1:1], ppuAddr[12]};
  end

  assign prgAddr = {prgBank & PRG_MASK, cpuAddr[PRG_OFS_W-1:0]};
  assign chrAddr = {chrBank & CHR_MASK, ppuAddr[CHR_OFS_W-1:0]};
  assign mirror  = ctrlReg[1:0];
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int PRG_BANKS16 = 8,
  parameter int CHR_BANKS4  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddrHi,
  input  logic              serBit,
  input  logic              serClear,
  input  logic [14:0]       cpuAddr,
  input  logic [12:0]       ppuAddr,
  output logic [PRG_AW-1:0] prgAddr,
  output logic [CHR_AW-1:0] chrAddr,
  output logic [1:0]        mirror
);
  sbc_strobe_t strb;

  sbc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddrHi(wrAddrHi),
    .serBit(serBit), .serClear(serClear), .strb(strb)
  );

  sbc_dp #(.PRG_BANKS16(PRG_BANKS16), .CHR_BANKS4(CHR_BANKS4)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr),
    .ppuAddr(ppuAddr), .prgAddr(prgAddr), .chrAddr(chrAddr), .mirror(mirror)
  );
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
  parameter int PRG_BANKS16 = 8,
  parameter int CHR_BANKS4  = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        winHit,
  input logic        serClear,
  input logic        abortS,
  input logic        commitS,
  input logic [1:0]  mirror,
  input logic [13:0] cpuLo,
  input logic [13:0] prgLo,
  input logic [3:0]  prgBank,
  input logic [11:0] ppuLo,
  input logic [11:0] chrLo,
  input logic [4:0]  chrBank
);
  localparam logic [3:0] PMASK = 4'(PRG_BANKS16 - 1);
  localparam logic [4:0] CMASK = 5'(CHR_BANKS4 - 1);

  logic [2:0] refCnt;
  logic       acc;
  assign acc = wrEn && winHit;

  always_ff @(posedge clk) begin
    if (!rstN) refCnt <= '0;
    else if (acc) begin
      if (serClear || refCnt == 3'd4) refCnt <= '0;
      else refCnt <= refCnt + 3'd1;
    end
  end

  // R3
  commit_on_fifth_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitS == (acc && !serClear && refCnt == 3'd4));

  // R2
  abort_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && serClear) |-> abortS);

  // R2
  abort_keeps_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortS |=> $stable(mirror));

  // R1
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acc |-> (!abortS && !commitS));

  // R1
  ignored_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acc |=> $stable(mirror));

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prgLo == cpuLo) && (chrLo == ppuLo));

  // R12
  bank_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((prgBank & ~PMASK) == 4'd0) && ((chrBank & ~CMASK) == 5'd0));
endmodule

bind serial_bank_ctrl sbc_chk #(.PRG_BANKS16(PRG_BANKS16), .CHR_BANKS4(CHR_BANKS4)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .winHit(wrAddrHi[2]), .serClear(serClear),
  .abortS(strb.abort), .commitS(strb.commit), .mirror(mirror),
  .cpuLo(cpuAddr[13:0]), .prgLo(prgAddr[13:0]), .prgBank(prgAddr[17:14]),
  .ppuLo(ppuAddr[11:0]), .chrLo(chrAddr[11:0]), .chrBank(chrAddr[16:12])
);

// File: tb/sim_serial_bank_ctrl.sv
module sim_serial_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // entry: {target[1:0], value[4:0], expLoBank[3:0], expHiBank[3:0], expMirror[1:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {2'd3, 5'b00101, 4'd5, 4'd7, 2'd0},
    {2'd0, 5'b01010, 4'd0, 4'd5, 2'd2},
    {2'd0, 5'b00011, 4'd4, 4'd5, 2'd3},
    {2'd3, 5'b01110, 4'd6, 4'd7, 2'd3}, // R12 wrap: bank 14 -> 6
    {2'd0, 5'b01101, 4'd6, 4'd7, 2'd1},
    {2'd3, 5'b10011, 4'd3, 4'd7, 2'd1},
    {2'd0, 5'b01000, 4'd0, 4'd3, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddrHi = 3'd0;
  logic        serBit = 1'b0;
  logic        serClear = 1'b0;
  logic [14:0] cpuAddr = 15'd0;
  logic [12:0] ppuAddr = 13'd0;
  logic [17:0] prgAddr;
  logic [16:0] chrAddr;
  logic [1:0]  mirror;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  serial_bank_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddrHi(wrAddrHi), .serBit(serBit),
    .serClear(serClear), .cpuAddr(cpuAddr), .ppuAddr(ppuAddr),
    .prgAddr(prgAddr), .chrAddr(chrAddr), .mirror(mirror)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] hi, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddrHi = hi; serBit = d[0]; serClear = d[7];
    @(negedge clk);
    wrEn = 1'b0; serClear = 1'b0;
  endtask

  task automatic loadReg(input logic [1:0] tgt, input logic [4:0] val);
    for (int i = 0; i < 5; i++) pulse({1'b1, tgt}, 8'h5A | {7'd0, val[i]});
  endtask

  task automatic chkPrg(input string req, input logic half, input logic [3:0] bank);
    cpuAddr = {half, 14'h1234};
    #1;
    check(req, 32'(prgAddr), 32'({bank, 14'h1234}));
  endtask

  task automatic chkChr(input string req, input logic [12:0] pa, input logic [16:0] exp);
    ppuAddr = pa;
    #1;
    check(req, 32'(chrAddr), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 mirror", 32'(mirror), 32'd0);
    chkPrg("R11 prg low", 1'b0, 4'd0);
    chkPrg("R11 prg high", 1'b1, 4'd7);
    chkChr("R11 chr", 13'h1000, 17'h01000);

    for (int v = 0; v < NVEC; v++) begin
      loadReg(VEC[v][16:15], VEC[v][14:10]);
      chkPrg("R4 R6 R7 R8 low", 1'b0, VEC[v][9:6]);
      chkPrg("R4 R6 R7 R8 high", 1'b1, VEC[v][5:2]);
      check("R5 mirror", 32'(mirror), 32'(VEC[v][1:0]));
    end

    // R1 writes below the window, including clearing ones, are ignored
    for (int i = 0; i < 5; i++) pulse(3'b011, 8'h01);
    pulse(3'b010, 8'h81);
    check("R1 mirror", 32'(mirror), 32'd0);
    chkPrg("R1 prg low", 1'b0, 4'd0);
    chkPrg("R1 prg high", 1'b1, 4'd3);
    loadReg(2'd3, 5'b00001);
    chkPrg("R1 shift untouched", 1'b1, 4'd1);

    // R3 four writes do not commit, the fifth does
    for (int i = 0; i < 4; i++) pulse(3'b111, {7'd0, i == 1 || i == 2});
    chkPrg("R3 no commit after four", 1'b1, 4'd1);
    pulse(3'b111, 8'h00);
    chkPrg("R3 commit on fifth", 1'b1, 4'd6);

    // R2 abort partway through a load
    loadReg(2'd3, 5'b00010);
    loadReg(2'd0, 5'b00010);
    chkPrg("R8 32k low", 1'b0, 4'd2);
    chkPrg("R8 32k high", 1'b1, 4'd3);
    pulse(3'b100, 8'h01);
    pulse(3'b100, 8'h01);
    pulse(3'b101, 8'h80);
    check("R2 mirror kept", 32'(mirror), 32'd2);
    chkPrg("R2 forced low", 1'b0, 4'd2);
    chkPrg("R2 forced high", 1'b1, 4'd7);
    loadReg(2'd3, 5'b00100);
    chkPrg("R2 shift cleared", 1'b0, 4'd4);

    // R10 and R9 pattern banking, R12 wrap on second register
    loadReg(2'd1, 5'd6);
    loadReg(2'd2, 5'd17);
    chkChr("R10 8k low", 13'h0abc, 17'h06abc);
    chkChr("R10 8k high", 13'h1abc, 17'h07abc);
    loadReg(2'd0, 5'b11110);
    chkChr("R9 4k low", 13'h0123, 17'h06123);
    chkChr("R9 R12 4k high wrap", 13'h1456, 17'h01456);
    check("R5 mirror vertical", 32'(mirror), 32'd2);

    // R11 reset in mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R11 mirror again", 32'(mirror), 32'd0);
    chkPrg("R11 prg high again", 1'b1, 4'd7);
    chkChr("R11 chr again", 13'h0800, 17'h00800);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule